// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel

This block receives start-stop serial frames on one input line and presents each received character, together with error status, as register-style outputs. The line is resynchronised into the operation clock. A falling edge at the active level starts a frame, and the start bit is confirmed half a bit period later. Each following bit is then sampled at its centre. The bit period comes from a 7-bit divider field.

Software-side logic reads the character through `rx_data` and acknowledges it with a one-cycle `rd_strobe`. Each error flag stays set until its own clear input is pulsed. A completed frame produces exactly one pulse: a transfer-end pulse if the frame was clean, or an error pulse if any error was found in it. The data length, the bit order, the line polarity and the parity handling are all configuration inputs. They are expected to stay constant while a frame is in flight.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, `rx_data` is 0, all three flags are 0, and both interrupt pulses are 0.
- R2: `cfg_len` 2'b00 selects 5 data bits, 2'b01 selects 7, and 2'b10 or 2'b11 select 8. The character is right-justified in `rx_data` and the unused upper bits read 0.
- R3: With `cfg_msb_first`=0, the first data bit received lands in bit 0 of `rx_data`. With `cfg_msb_first`=1, it lands in bit (length-1).
- R4: With `cfg_invert`=1, the idle level is low, the start bit is high, and every sampled bit is complemented before it is decoded.
- R5: One bit lasts 2*(`cfg_div`+1) clocks, where `cfg_div` is at least 2. Suppose the active start level is driven right after clock edge E. Then the outputs update at edge E+3+(`cfg_div`+1)+(n+1)*2*(`cfg_div`+1), where n counts the data bits plus any parity bit.
- R6: A start-level pulse shorter than `cfg_div`+1 clocks is discarded, and no output changes.
- R7: `cfg_parity` selects the parity handling. 2'b00 means no parity bit. 2'b01 means a parity bit is received but never checked. 2'b10 means even parity over data plus parity bit. 2'b11 means odd parity over data plus parity bit. A mismatch in the two checked modes sets `flag_pe`.
- R8: If the stop bit is sampled at the active (start) level, `flag_fe` is set. The character is still stored.
- R9: If a frame completes while the previous character has not been acknowledged by `rd_strobe`, `flag_ovf` is set. In that case `rx_data` takes the new character. `rx_data` changes only when a frame completes.
- R10: Every completed frame gives a one-cycle pulse, and only one of the two kinds. `irq_err` pulses if the frame raised a framing, parity or overrun error. Otherwise `irq_done` pulses.
- R11: Each flag stays set until a one-cycle pulse on its own clear input. Clearing one flag leaves the others unchanged. A set in the same cycle as a clear wins.
- R12: A frame starts only on a transition from idle level to active level. A line that stays at the active level after a low stop bit starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive line |
| cfg_div | input | 7 | Divider field; half bit = cfg_div+1 clocks |
| cfg_len | input | 2 | Data length code |
| cfg_msb_first | input | 1 | 1: most significant bit received first |
| cfg_invert | input | 1 | 1: line polarity inverted |
| cfg_parity | input | 2 | Parity handling code |
| rd_strobe | input | 1 | Acknowledge that rx_data was read |
| clr_fe | input | 1 | Clear framing flag |
| clr_pe | input | 1 | Clear parity flag |
| clr_ovf | input | 1 | Clear overrun flag |
| rx_data | output | 8 | Last received character |
| flag_fe | output | 1 | Sticky framing error |
| flag_pe | output | 1 | Sticky parity error |
| flag_ovf | output | 1 | Sticky overrun error |
| irq_done | output | 1 | Clean frame completion pulse |
| irq_err | output | 1 | Erroneous frame completion pulse |

## Verification
The hardest cases to reach from the pins are those that depend on what happened before the current frame. One is an overrun, which needs two complete frames with no acknowledge between them. Another is a line still held at the start level after a bad stop bit, which must not start a phantom frame. The stimulus builds these by chaining whole frames, deliberately leaving out the acknowledge, and driving a stop bit at the wrong level and then holding it for several bit periods. Short start glitches just under half a bit are also injected. A behavioural model predicts the exact completion edge of every frame, and the outputs are compared with it on every clock, so any shift in the sampling point shows up.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ZERO = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_mode_e;

    // data bits per frame for a length code
    function automatic int unsigned frame_len(input logic [1:0] code);
        case (code)
            2'b00:   return 5;
            2'b01:   return 7;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
// Polarity correction, resynchroniser and start-edge detector.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic invert_i,
    output logic bit_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic              prev;
    } sync_s;

    sync_s st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = line_i ^ invert_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        st_d.prev   = st_q.stg[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign bit_o  = st_q.stg[STAGES-1];
    assign fall_o = st_q.prev & ~st_q.stg[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
`timescale 1ns/1ps
// Bit timing, frame sequencing and character assembly.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              fall_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [1:0]        cfg_len_i,
    input  logic              cfg_msb_first_i,
    input  par_mode_e         cfg_par_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              fe_o,
    output logic              pe_o
);

    localparam int CNT_W = DIV_W + 2;
    localparam int IDX_W = $clog2(DATA_W);
    localparam int LEN_W = IDX_W + 1;

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shift;
        logic              par;
    } frm_s;

    frm_s st_q, st_d;

    logic [CNT_W-1:0] half, full;
    logic [LEN_W-1:0] nbits, idx_w;
    logic [IDX_W-1:0] pos;
    logic             tick, last;

    always_comb begin
        st_d  = st_q;
        half  = CNT_W'(cfg_div_i) + CNT_W'(1);
        full  = half << 1;
        nbits = LEN_W'(frame_len(cfg_len_i));
        idx_w = {1'b0, st_q.idx};
        last  = (idx_w == nbits - LEN_W'(1));
        pos   = cfg_msb_first_i ? IDX_W'(nbits - LEN_W'(1) - idx_w) : st_q.idx;
        tick  = (st_q.cnt == '0);
        if (!tick) st_d.cnt = st_q.cnt - CNT_W'(1);

        case (st_q.state)
            ST_IDLE: begin
                if (fall_i) begin
                    st_d.state = ST_START;
                    st_d.cnt   = half - CNT_W'(1);
                    st_d.shift = '0;
                    st_d.idx   = '0;
                    st_d.par   = 1'b0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (!bit_i) begin
                        st_d.state = ST_DATA;
                        st_d.cnt   = full - CNT_W'(1);
                    end else begin
                        st_d.state = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    st_d.shift[pos] = bit_i;
                    st_d.idx        = st_q.idx + IDX_W'(1);
                    st_d.cnt        = full - CNT_W'(1);
                    if (last) st_d.state = (cfg_par_i == PAR_NONE) ? ST_STOP : ST_PAR;
                end
            end
            ST_PAR: begin
                if (tick) begin
                    st_d.par   = bit_i;
                    st_d.state = ST_STOP;
                    st_d.cnt   = full - CNT_W'(1);
                end
            end
            ST_STOP: begin
                if (tick) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        done_o = (st_q.state == ST_STOP) && tick;
        data_o = st_q.shift;
        fe_o   = ~bit_i;
        case (cfg_par_i)
            PAR_EVEN: pe_o = ^{st_q.shift, st_q.par};
            PAR_ODD:  pe_o = ~^{st_q.shift, st_q.par};
            default:  pe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
// Receive buffer, sticky error flags and completion pulses.
module uart_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              fe_i,
    input  logic              pe_i,
    input  logic              rd_i,
    input  logic              clr_fe_i,
    input  logic              clr_pe_i,
    input  logic              clr_ovf_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              ovf_o,
    output logic              irq_done_o,
    output logic              irq_err_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              unread;
        logic              fe;
        logic              pe;
        logic              ovf;
        logic              irq_done;
        logic              irq_err;
    } stat_s;

    stat_s st_q, st_d;
    logic  set_fe, set_pe, set_ovf, err_now;

    always_comb begin
        st_d    = st_q;
        set_fe  = done_i & fe_i;
        set_pe  = done_i & pe_i;
        set_ovf = done_i & st_q.unread & ~rd_i;
        err_now = set_fe | set_pe | set_ovf;

        if (done_i) begin
            st_d.data   = data_i;
            st_d.unread = 1'b1;
        end else if (rd_i) begin
            st_d.unread = 1'b0;
        end

        st_d.fe       = set_fe  | (st_q.fe  & ~clr_fe_i);
        st_d.pe       = set_pe  | (st_q.pe  & ~clr_pe_i);
        st_d.ovf      = set_ovf | (st_q.ovf & ~clr_ovf_i);
        st_d.irq_err  = err_now;
        st_d.irq_done = done_i & ~err_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o     = st_q.data;
    assign fe_o       = st_q.fe;
    assign pe_o       = st_q.pe;
    assign ovf_o      = st_q.ovf;
    assign irq_done_o = st_q.irq_done;
    assign irq_err_o  = st_q.irq_err;

endmodule

// File: rtl/uart_rx_chan.sv
`timescale 1ns/1ps
module uart_rx_chan
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_parity,
    input  logic              rd_strobe,
    input  logic              clr_fe,
    input  logic              clr_pe,
    input  logic              clr_ovf,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_fe,
    output logic              flag_pe,
    output logic              flag_ovf,
    output logic              irq_done,
    output logic              irq_err
);

    logic              line_bit, line_fall;
    logic              frm_done, frm_fe, frm_pe;
    logic [DATA_W-1:0] frm_data;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (rx_line),
        .invert_i (cfg_invert),
        .bit_o    (line_bit),
        .fall_o   (line_fall)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_frame (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_i           (line_bit),
        .fall_i          (line_fall),
        .cfg_div_i       (cfg_div),
        .cfg_len_i       (cfg_len),
        .cfg_msb_first_i (cfg_msb_first),
        .cfg_par_i       (par_mode_e'(cfg_parity)),
        .done_o          (frm_done),
        .data_o          (frm_data),
        .fe_o            (frm_fe),
        .pe_o            (frm_pe)
    );

    uart_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (frm_done),
        .data_i     (frm_data),
        .fe_i       (frm_fe),
        .pe_i       (frm_pe),
        .rd_i       (rd_strobe),
        .clr_fe_i   (clr_fe),
        .clr_pe_i   (clr_pe),
        .clr_ovf_i  (clr_ovf),
        .data_o     (rx_data),
        .fe_o       (flag_fe),
        .pe_o       (flag_pe),
        .ovf_o      (flag_ovf),
        .irq_done_o (irq_done),
        .irq_err_o  (irq_err)
    );

endmodule

// File: rtl/uart_rx_chan_chk.sv
`timescale 1ns/1ps
module uart_rx_chan_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_parity,
    input logic              clr_fe,
    input logic              clr_pe,
    input logic              clr_ovf,
    input logic [DATA_W-1:0] rx_data,
    input logic              flag_fe,
    input logic              flag_pe,
    input logic              flag_ovf,
    input logic              irq_done,
    input logic              irq_err,
    input logic              frm_done,
    input logic              frm_fe,
    input logic              frm_pe
);

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(irq_done && irq_err)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_done |=> !irq_done); // R10
    AST_ERR_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_err |-> (flag_fe || flag_pe || flag_ovf)); // R10
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag_fe) |-> $past(clr_fe)); // R11
    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag_pe) |-> $past(clr_pe)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag_ovf) |-> $past(clr_ovf)); // R11
    AST_UNCHECKED_PARITY: assert property (@(posedge clk) disable iff (!rst_n) (frm_done && !cfg_parity[1]) |-> !frm_pe); // R7
    AST_STOP_LOW_FE: assert property (@(posedge clk) disable iff (!rst_n) (frm_done && frm_fe) |=> flag_fe); // R8
    AST_OVF_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_ovf) |-> $past(frm_done)); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$past(frm_done) |-> $stable(rx_data)); // R9

endmodule

bind uart_rx_chan uart_rx_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_parity (cfg_parity),
    .clr_fe     (clr_fe),
    .clr_pe     (clr_pe),
    .clr_ovf    (clr_ovf),
    .rx_data    (rx_data),
    .flag_fe    (flag_fe),
    .flag_pe    (flag_pe),
    .flag_ovf   (flag_ovf),
    .irq_done   (irq_done),
    .irq_err    (irq_err),
    .frm_done   (frm_done),
    .frm_fe     (frm_fe),
    .frm_pe     (frm_pe)
);

// File: tb/uart_rx_chan_tb.sv
`timescale 1ns/1ps
module uart_rx_chan_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [6:0] cfg_div = 7'd5;
    logic [1:0] cfg_len = 2'd2;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_parity = 2'd0;
    logic       rd_strobe = 1'b0, clr_fe = 1'b0, clr_pe = 1'b0, clr_ovf = 1'b0;
    logic [7:0] rx_data;
    logic       flag_fe, flag_pe, flag_ovf, irq_done, irq_err;

    always #4 clk = ~clk;

    uart_rx_chan u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_div(cfg_div),
        .cfg_len(cfg_len), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_parity(cfg_parity), .rd_strobe(rd_strobe), .clr_fe(clr_fe),
        .clr_pe(clr_pe), .clr_ovf(clr_ovf), .rx_data(rx_data), .flag_fe(flag_fe),
        .flag_pe(flag_pe), .flag_ovf(flag_ovf), .irq_done(irq_done), .irq_err(irq_err)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // values of the bench-driven inputs at the last rising edge
    logic c_rst = 1'b0, c_rd = 1'b0, c_cfe = 1'b0, c_cpe = 1'b0, c_covf = 1'b0;
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        c_rst  <= rst_n;
        c_rd   <= rd_strobe;
        c_cfe  <= clr_fe;
        c_cpe  <= clr_pe;
        c_covf <= clr_ovf;
    end

    // behavioural reference: a queue of predicted frame completions
    typedef struct {
        int         at;
        logic [7:0] d;
        bit         fe;
        bit         pe;
    } ev_t;
    ev_t        evq[$];
    ev_t        ev;
    logic [7:0] m_data = 8'h00;
    bit         m_fe = 0, m_pe = 0, m_ovf = 0, m_unread = 0, m_done = 0, m_err = 0;
    bit         sf, sp, so;

    always @(negedge clk) begin
        if (!finished) begin
            if (!c_rst) begin
                m_data = 8'h00; m_fe = 0; m_pe = 0; m_ovf = 0;
                m_unread = 0; m_done = 0; m_err = 0;
                evq.delete();
            end else begin
                sf = 0; sp = 0; so = 0; m_done = 0; m_err = 0;
                if (evq.size() > 0 && evq[0].at == cyc) begin
                    ev = evq.pop_front();
                    so = m_unread && !c_rd;
                    sf = ev.fe;
                    sp = ev.pe;
                    m_data = ev.d;
                    m_unread = 1;
                    if (sf || sp || so) m_err = 1;
                    else m_done = 1;
                end else if (c_rd) begin
                    m_unread = 0;
                end
                m_fe  = sf | (m_fe  & !c_cfe);
                m_pe  = sp | (m_pe  & !c_cpe);
                m_ovf = so | (m_ovf & !c_covf);
            end
            total++;
            if ({rx_data, flag_fe, flag_pe, flag_ovf, irq_done, irq_err} !==
                {m_data, m_fe, m_pe, m_ovf, m_done, m_err}) begin
                bad++;
                $display("FAIL %s cycle=%0d got data=%h fe%b pe%b ovf%b done%b err%b exp data=%h fe%b pe%b ovf%b done%b err%b",
                         cur_req, cyc, rx_data, flag_fe, flag_pe, flag_ovf, irq_done, irq_err,
                         m_data, m_fe, m_pe, m_ovf, m_done, m_err);
            end
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0; tick(1);
    endtask

    task automatic pulse_clr(input bit f, input bit p, input bit o);
        clr_fe = f; clr_pe = p; clr_ovf = o; tick(1);
        clr_fe = 1'b0; clr_pe = 1'b0; clr_ovf = 1'b0; tick(1);
    endtask

    // drive one frame from a negedge; flip_par corrupts the parity bit,
    // stop_lvl is the logical stop value, hold keeps the line active afterwards
    task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stop_lvl, input bit hold);
        int   len, hb, fb, nb, e;
        logic bits[$];
        logic [7:0] dm;
        logic p;
        len = (cfg_len == 2'd0) ? 5 : (cfg_len == 2'd1) ? 7 : 8;
        dm  = d & 8'((1 << len) - 1);
        hb  = int'(cfg_div) + 1;
        fb  = 2 * hb;
        bits.push_back(1'b0);
        for (int i = 0; i < len; i++) bits.push_back(dm[cfg_msb_first ? (len - 1 - i) : i]);
        nb = len;
        if (cfg_parity != 2'd0) begin
            p = (cfg_parity == 2'd2) ? ^dm : (cfg_parity == 2'd3) ? ~^dm : 1'b0;
            bits.push_back(p ^ flip_par);
            nb++;
        end
        bits.push_back(stop_lvl);
        e = cyc;
        evq.push_back('{at: e + 3 + hb + (nb + 1) * fb, d: dm,
                        fe: !stop_lvl, pe: (cfg_parity[1] && flip_par)});
        foreach (bits[k]) begin
            rx_line = bits[k] ^ cfg_invert;
            tick(fb);
        end
        if (!hold) rx_line = 1'b1 ^ cfg_invert;
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R5 watchdog got=hung exp=finished");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        cur_req = "R1";
        chk({rx_data[7:3], flag_fe, flag_pe, flag_ovf}, 8'h00, "R1");
        chk({rx_data[2:0], irq_done, irq_err}, 8'h00, "R1");

        // R2 R3 R5: 8-bit, LSB first, no parity
        cur_req = "R5";
        send_frame(8'hA5, 0, 1, 0);
        chk(rx_data, 8'hA5, "R5");
        pulse_rd();

        // R2: 5-bit, upper bits zero
        cur_req = "R2";
        cfg_len = 2'd0;
        send_frame(8'hF3, 0, 1, 0);
        chk(rx_data, 8'h13, "R2");
        pulse_rd();

        // R3: 7-bit, MSB first
        cur_req = "R3";
        cfg_len = 2'd1; cfg_msb_first = 1'b1;
        send_frame(8'h4B, 0, 1, 0);
        chk(rx_data, 8'h4B, "R3");
        pulse_rd();
        cfg_len = 2'd2;
        send_frame(8'h81, 0, 1, 0);
        chk(rx_data, 8'h81, "R3");
        pulse_rd();
        cfg_msb_first = 1'b0;

        // R4: inverted polarity, idle low
        cur_req = "R4";
        cfg_invert = 1'b1; rx_line = 1'b0;
        tick(6);
        send_frame(8'h3C, 0, 1, 0);
        chk(rx_data, 8'h3C, "R4");
        pulse_rd();
        cfg_parity = 2'd2;
        send_frame(8'h07, 0, 1, 0);
        chk({7'd0, flag_pe}, 8'h00, "R4");
        pulse_rd();
        cfg_invert = 1'b0; rx_line = 1'b1;
        tick(6);

        // R7: even and odd checked, zero mode unchecked
        cur_req = "R7";
        send_frame(8'h96, 0, 1, 0);
        chk({7'd0, flag_pe}, 8'h00, "R7");
        pulse_rd();
        send_frame(8'h96, 1, 1, 0);
        chk({7'd0, flag_pe}, 8'h01, "R7");
        pulse_rd();
        cur_req = "R11";
        pulse_clr(0, 1, 0);
        chk({7'd0, flag_pe}, 8'h00, "R11");
        cur_req = "R7";
        cfg_parity = 2'd3;
        send_frame(8'h5E, 0, 1, 0);
        pulse_rd();
        send_frame(8'h5E, 1, 1, 0);
        chk({7'd0, flag_pe}, 8'h01, "R7");
        pulse_rd();
        pulse_clr(0, 1, 0);
        cfg_parity = 2'd1;
        send_frame(8'h00, 1, 1, 0);
        chk({7'd0, flag_pe}, 8'h00, "R7");
        pulse_rd();
        cfg_parity = 2'd0;

        // R8 and R12: low stop bit, line then held active
        cur_req = "R8";
        send_frame(8'h6D, 0, 0, 1);
        chk({7'd0, flag_fe}, 8'h01, "R8");
        chk(rx_data, 8'h6D, "R8");
        pulse_rd();
        cur_req = "R12";
        tick(3 * 12);
        rx_line = 1'b1;
        tick(8);
        chk(rx_data, 8'h6D, "R12");
        cur_req = "R11";
        send_frame(8'h11, 1, 1, 0);
        pulse_rd();
        pulse_clr(1, 0, 0);
        chk({6'd0, flag_fe, flag_pe}, 8'h00, "R11");

        // R9 R10: overrun without acknowledge
        cur_req = "R9";
        send_frame(8'h22, 0, 1, 0);
        send_frame(8'h44, 0, 1, 0);
        chk(rx_data, 8'h44, "R9");
        chk({7'd0, flag_ovf}, 8'h01, "R9");
        pulse_rd();
        cur_req = "R10";
        pulse_clr(0, 0, 1);
        send_frame(8'h55, 0, 1, 0);
        chk({7'd0, flag_ovf}, 8'h00, "R10");
        pulse_rd();

        // R6: glitch shorter than half a bit
        cur_req = "R6";
        rx_line = 1'b0;
        tick(int'(cfg_div));
        rx_line = 1'b1;
        tick(20);
        chk(rx_data, 8'h55, "R6");
        send_frame(8'hC3, 0, 1, 0);
        chk(rx_data, 8'hC3, "R6");
        pulse_rd();

        // R5: fastest divider, and a slower one
        cur_req = "R5";
        cfg_div = 7'd2;
        send_frame(8'h9A, 0, 1, 0);
        chk(rx_data, 8'h9A, "R5");
        pulse_rd();
        cfg_div = 7'd9; cfg_parity = 2'd2;
        send_frame(8'h7E, 0, 1, 0);
        chk(rx_data, 8'h7E, "R5");
        pulse_rd();

        tick(10);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule